// File: doc/BRIEF.md
# Paged Extended Data Window Translator

This block sits between a CPU's 16-bit data address bus and a 24-bit memory system. The lower half of the data space, below 8000h, is passed straight through to base data memory. Special function registers sit at 0000h to 07FFh, and internal RAM starts at 0800h. An access to the upper half, 8000h to FFFFh, goes through a 32-Kbyte window instead. A page number extends the 15-bit window offset into a wider address.

There are two page registers, one for reads and one for writes. Each can be loaded through a small configuration write port. The block picks the page register that matches the access direction. It then decodes the page value to choose a target. The targets are an external parallel memory port, or, for reads only, the low or the high word of program memory.

Some window accesses are illegal: any access while the selected page is zero, and any write toward a program page. These raise a one-cycle address error trap, and no memory strobe is issued for them. Every result is registered and appears exactly one clock after the request.

Top module: `edw_xlate`

## Requirements
- R1: Synchronous reset, active high, sets both page registers to 001h and drives every output to zero. After reset, a window read or write reaches external memory at page 001h, so offset 0 maps to 008000h.
- R2: A request with addr[15]=0 gives base_stb one cycle later. On that cycle base_addr equals the request address and base_we equals the request's write flag. No page register has any effect on it.
- R3: When cfg_we is high, cfg_sel=0 loads the read page register and cfg_sel=1 loads the write page register, from cfg_wdata. The new value applies from the next cycle on. An access in the same cycle as the load still uses the old value.
- R4: A window access whose selected page is 001h to 1FFh gives ext_stb. On that cycle ext_addr = {page[8:0], addr[14:0]} and ext_we is the write flag. Reads select the read page register and writes select the write page register.
- R5: A window read with read page 200h to 2FFh gives prog_stb with prog_hi=0 and prog_addr = {page[7:0], addr[14:0]}. Page 200h offset 0 maps to 000000h, and page 2FFh offset 7FFEh maps to 7FFFFEh.
- R6: A window read with read page 300h to 3FFh gives prog_stb with prog_hi=1 and the same prog_addr formula. Page 3FFh offset 7FFFh maps to 7FFFFFh.
- R7: A window access whose selected page is 000h gives trap for one cycle and no strobe.
- R8: A window write with write page 200h or above gives trap for one cycle and no strobe. No write ever produces prog_stb.
- R9: Every output is registered with a latency of one cycle. At most one of base_stb, ext_stb, prog_stb and trap is high in any cycle. A cycle without a request gives none of them. Address, write and half-select outputs of a port whose strobe is low read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Page register load enable |
| cfg_sel | input | 1 | 0 selects the read page register, 1 selects the write page register |
| cfg_wdata | input | 10 | Page value to load |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 16 | Data address |
| base_stb | output | 1 | Base data memory access |
| base_we | output | 1 | Base access is a write |
| base_addr | output | 16 | Base data address |
| ext_stb | output | 1 | External memory access |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 24 | External effective address |
| prog_stb | output | 1 | Program memory read |
| prog_hi | output | 1 | 1 selects the upper program word, 0 the lower |
| prog_addr | output | 23 | Program word address |
| trap | output | 1 | Address error trap pulse |

## Verification
The assertions take for granted that cpu_req, cpu_we, cpu_addr and the configuration inputs are steady around each rising edge. They also assume that no request is issued while reset is high. As a result, every output cycle after reset comes from a request sampled with reset low. The stimulus drives all inputs on the falling edge and keeps cpu_req low throughout reset. Its random phase draws page values with a bias toward the range boundaries 000h, 001h, 1FFh, 200h, 2FFh, 300h and 3FFh, and often loads a page in the same cycle as an access to it.

// File: rtl/edw_pkg.sv
package edw_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BASE,
    TGT_EXT,
    TGT_PLO,
    TGT_PHI,
    TGT_TRAP
  } tgt_e;
endpackage

// File: rtl/edw_page_regs.sv
module edw_page_regs #(
  parameter int PAGE_W   = 10,
  parameter int RST_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic [PAGE_W-1:0] rd_page,
  output logic [PAGE_W-1:0] wr_page
);
  localparam int NREG = 2;

  logic [PAGE_W-1:0] pg_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        pg_q[i] <= PAGE_W'(RST_PAGE);
      else if (cfg_we && (cfg_sel == 1'(i)))
        pg_q[i] <= cfg_wdata;
    end
  end

  assign rd_page = pg_q[0];
  assign wr_page = pg_q[1];
endmodule

// File: rtl/edw_route.sv
module edw_route
  import edw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 10
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [PAGE_W-1:0] wr_page,
  output tgt_e              tgt,
  output logic [PAGE_W-1:0] page
);
  logic in_win;
  logic prog_rng;
  logic hi_half;

  assign in_win   = addr[ADDR_W-1];
  assign page     = we ? wr_page : rd_page;
  assign prog_rng = page[PAGE_W-1];
  assign hi_half  = page[PAGE_W-2];

  always_comb begin
    if (!req)                  tgt = TGT_NONE;
    else if (!in_win)          tgt = TGT_BASE;
    else if (page == '0)       tgt = TGT_TRAP;
    else if (!prog_rng)        tgt = TGT_EXT;
    else if (we)               tgt = TGT_TRAP;
    else if (hi_half)          tgt = TGT_PHI;
    else                       tgt = TGT_PLO;
  end
endmodule

// File: rtl/edw_issue.sv
module edw_issue
  import edw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 10,
  localparam int OFF_W = ADDR_W - 1,
  localparam int EA_W  = PAGE_W - 1 + OFF_W,
  localparam int PA_W  = PAGE_W - 2 + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tgt_e              tgt,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic              base_stb,
  output logic              base_we,
  output logic [ADDR_W-1:0] base_addr,
  output logic              ext_stb,
  output logic              ext_we,
  output logic [EA_W-1:0]   ext_addr,
  output logic              prog_stb,
  output logic              prog_hi,
  output logic [PA_W-1:0]   prog_addr,
  output logic              trap
);
  logic [OFF_W-1:0] off;
  assign off = addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_stb  <= 1'b0;
      base_we   <= 1'b0;
      base_addr <= '0;
      ext_stb   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      prog_stb  <= 1'b0;
      prog_hi   <= 1'b0;
      prog_addr <= '0;
      trap      <= 1'b0;
    end else begin
      base_stb  <= 1'b0;
      base_we   <= 1'b0;
      base_addr <= '0;
      ext_stb   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      prog_stb  <= 1'b0;
      prog_hi   <= 1'b0;
      prog_addr <= '0;
      trap      <= 1'b0;
      case (tgt)
        TGT_BASE: begin
          base_stb  <= 1'b1;
          base_we   <= we;
          base_addr <= addr;
        end
        TGT_EXT: begin
          ext_stb  <= 1'b1;
          ext_we   <= we;
          ext_addr <= {page[PAGE_W-2:0], off};
        end
        TGT_PLO, TGT_PHI: begin
          prog_stb  <= 1'b1;
          prog_hi   <= (tgt == TGT_PHI);
          prog_addr <= {page[PAGE_W-3:0], off};
        end
        TGT_TRAP: trap <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/edw_xlate.sv
module edw_xlate
  import edw_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 10,
  parameter int RST_PAGE = 1,
  localparam int OFF_W   = ADDR_W - 1,
  localparam int EA_W    = PAGE_W - 1 + OFF_W,
  localparam int PA_W    = PAGE_W - 2 + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              base_stb,
  output logic              base_we,
  output logic [ADDR_W-1:0] base_addr,
  output logic              ext_stb,
  output logic              ext_we,
  output logic [EA_W-1:0]   ext_addr,
  output logic              prog_stb,
  output logic              prog_hi,
  output logic [PA_W-1:0]   prog_addr,
  output logic              trap
);
  logic [PAGE_W-1:0] rd_page;
  logic [PAGE_W-1:0] wr_page;
  logic [PAGE_W-1:0] sel_page;
  tgt_e              tgt;

  edw_page_regs #(.PAGE_W(PAGE_W), .RST_PAGE(RST_PAGE)) u_pages (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .rd_page   (rd_page),
    .wr_page   (wr_page)
  );

  edw_route #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_route (
    .req     (cpu_req),
    .we      (cpu_we),
    .addr    (cpu_addr),
    .rd_page (rd_page),
    .wr_page (wr_page),
    .tgt     (tgt),
    .page    (sel_page)
  );

  edw_issue #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .tgt       (tgt),
    .we        (cpu_we),
    .addr      (cpu_addr),
    .page      (sel_page),
    .base_stb  (base_stb),
    .base_we   (base_we),
    .base_addr (base_addr),
    .ext_stb   (ext_stb),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .prog_stb  (prog_stb),
    .prog_hi   (prog_hi),
    .prog_addr (prog_addr),
    .trap      (trap)
  );
endmodule

// File: rtl/edw_checker.sv
module edw_checker #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 10,
  localparam int OFF_W = ADDR_W - 1,
  localparam int EA_W  = PAGE_W - 1 + OFF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              base_stb,
  input logic [ADDR_W-1:0] base_addr,
  input logic              ext_stb,
  input logic [EA_W-1:0]   ext_addr,
  input logic              prog_stb,
  input logic              trap
);
  // R9: one target per cycle
  a_r9_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({base_stb, ext_stb, prog_stb, trap}));

  // R9: idle request cycle yields nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> !(base_stb || ext_stb || prog_stb || trap));

  // R2: lower half bypasses the window
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_addr[ADDR_W-1]) |=> (base_stb && base_addr == $past(cpu_addr)));

  // R7: window accesses never reach base memory
  a_r7_window_not_base: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_addr[ADDR_W-1]) |=> !base_stb);

  // R8: writes never reach program memory
  a_r8_no_prog_write: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we) |=> !prog_stb);

  // R4: window offset kept in the external address
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_addr[ADDR_W-1]) |=>
      (!ext_stb || ext_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0])));
endmodule

bind edw_xlate edw_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_edw_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .base_stb  (base_stb),
  .base_addr (base_addr),
  .ext_stb   (ext_stb),
  .ext_addr  (ext_addr),
  .prog_stb  (prog_stb),
  .trap      (trap)
);

// File: tb/test_edw_xlate.sv
module test_edw_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [9:0]  cfg_wdata = '0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        base_stb, base_we, ext_stb, ext_we, prog_stb, prog_hi, trap;
  logic [15:0] base_addr;
  logic [23:0] ext_addr;
  logic [22:0] prog_addr;

  edw_xlate i_edw_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .base_stb(base_stb), .base_we(base_we), .base_addr(base_addr),
    .ext_stb(ext_stb), .ext_we(ext_we), .ext_addr(ext_addr),
    .prog_stb(prog_stb), .prog_hi(prog_hi), .prog_addr(prog_addr), .trap(trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int rp = 1, wp = 1;
  int since_rst = 0;
  bit cfg_prev = 0;
  bit have_exp = 0;
  logic [69:0] exp_v;
  string tag = "R1";

  always @(posedge clk) begin
    logic e_bs, e_bw, e_es, e_ew, e_ps, e_ph, e_tr;
    int e_ba, e_ea, e_pa, pg, off;
    e_bs = 0; e_bw = 0; e_es = 0; e_ew = 0; e_ps = 0; e_ph = 0; e_tr = 0;
    e_ba = 0; e_ea = 0; e_pa = 0;
    if (rst) begin
      rp = 1; wp = 1; since_rst = 0; cfg_prev = 0;
      tag = "R1";
    end else begin
      off = int'(cpu_addr) % 32768;
      pg  = cpu_we ? wp : rp;
      if (!cpu_req) tag = "R9";
      else if (cpu_addr < 16'h8000) begin
        e_bs = 1; e_bw = cpu_we; e_ba = int'(cpu_addr); tag = "R2";
      end else if (pg == 0) begin
        e_tr = 1; tag = "R7";
      end else if (pg < 'h200) begin
        e_es = 1; e_ew = cpu_we; e_ea = pg * 32768 + off; tag = "R4";
      end else if (cpu_we) begin
        e_tr = 1; tag = "R8";
      end else begin
        e_ps = 1; e_ph = (pg >= 'h300); e_pa = (pg % 256) * 32768 + off;
        tag = e_ph ? "R6" : "R5";
      end
      if (cpu_req && (cfg_we || cfg_prev)) tag = "R3";
      if (cpu_req && since_rst < 6) tag = "R1";
      cfg_prev = cfg_we;
      if (cfg_we) begin
        if (cfg_sel) wp = int'(cfg_wdata); else rp = int'(cfg_wdata);
      end
      since_rst++;
    end
    exp_v = {e_bs, e_bw, 16'(e_ba), e_es, e_ew, 24'(e_ea), e_ps, e_ph, 23'(e_pa), e_tr};
    have_exp = 1;
  end

  always @(negedge clk) begin
    logic [69:0] act;
    if (have_exp && !done) begin
      act = {base_stb, base_we, base_addr, ext_stb, ext_we, ext_addr,
             prog_stb, prog_hi, prog_addr, trap};
      n_chk++;
      if (act !== exp_v) begin
        n_bad++;
        $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
      end
    end
  end

  task automatic drive(input bit cw, input bit cs, input int cv,
                       input bit rq, input bit w, input int a);
    @(negedge clk);
    cfg_we = cw; cfg_sel = cs; cfg_wdata = 10'(cv);
    cpu_req = rq; cpu_we = w; cpu_addr = 16'(a);
  endtask

  function automatic int pick_page();
    int r = $urandom_range(0, 9);
    case (r)
      0: return 0;
      1: return 1;
      2: return 'h1FF;
      3: return 'h200;
      4: return 'h2FF;
      5: return 'h300;
      6: return 'h3FF;
      default: return $urandom_range(0, 1023);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: default page 001h for both directions
    drive(0, 0, 0, 1, 0, 'h8000);     // 008000h
    drive(0, 0, 0, 1, 1, 'hFFFE);     // 00FFFEh write
    drive(0, 0, 0, 0, 0, 0);
    // R2: lower half pass-through
    drive(0, 0, 0, 1, 0, 'h0800);
    drive(0, 0, 0, 1, 1, 'h07FF);
    drive(0, 0, 0, 1, 0, 'h7FFF);
    drive(0, 0, 0, 0, 0, 0);
    // R4: top external page
    drive(1, 0, 'h1FF, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 'hFFFE);     // FFFFFEh
    drive(0, 0, 0, 0, 0, 0);
    // R3: same-cycle load uses old page, next cycle new
    drive(1, 0, 'h200, 1, 0, 'h8000); // old 1FFh -> FF8000h
    drive(0, 0, 0, 1, 0, 'h8000);     // R5 000000h
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 0, 'h2FF, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 'hFFFE);     // R5 7FFFFEh
    // R6: upper program word
    drive(1, 0, 'h300, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 'h8000);
    drive(1, 0, 'h3FF, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 'hFFFF);     // 7FFFFFh
    // R7: page zero traps, lower half unaffected
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 'h8000);
    drive(0, 0, 0, 1, 0, 'h7FFE);
    drive(1, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 1, 'h8000);
    // R8: writes toward program pages trap
    drive(1, 1, 'h200, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 1, 'h9000);
    drive(1, 1, 'h3FF, 0, 0, 0);
    drive(1, 0, 'h3FF, 0, 0, 0);
    drive(0, 0, 0, 1, 1, 'hA000);
    drive(0, 0, 0, 1, 0, 'hA000);     // read on same page still works
    drive(1, 1, 'h1FF, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 1, 'h8002);     // R4 write FF8002h
    // R9: idle cycles
    drive(0, 0, 0, 0, 1, 'hFFFF);
    drive(0, 0, 0, 0, 0, 'h1234);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit cw = ($urandom_range(0, 3) == 0);
      drive(cw, 1'($urandom_range(0, 1)), pick_page(),
            ($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)),
            int'($urandom_range(0, 65535)));
    end
    // reset mid-stream returns pages to 001h (R1)
    drive(1, 0, 'h300, 0, 0, 0);
    @(negedge clk); rst = 1'b1; cfg_we = 0; cpu_req = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(0, 0, 0, 1, 0, 'h8004);
    drive(0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end
endmodule